// File: doc/BRIEF.md
# Rule 90/150 Cellular Automaton Register

This block is a one-dimensional linear cellular automaton register for built-in self-test. It holds one flip-flop per cell. On each enabled clock, every cell takes the XOR of its two adjacent cells. A cell marked as rule 150 in a parameter vector also folds its own present state into that XOR. Only adjacent cells are wired together, so no feedback wire spans the register. The two end cells see a constant zero in place of their missing neighbour. The pattern of rule 90 and rule 150 cells sets the characteristic polynomial. That pattern is a parameter and is not derived inside the block.

The block has three working modes. In generate mode it takes no external data and steps through a pseudo-random sequence; its state word drives a circuit under test. In serial compaction mode, one serial bit is XORed into each end cell. In parallel compaction mode, a whole response word is XORed into the cells, one bit per cell. A load input writes a seed and takes priority over everything else. A compare output reports whether the present state equals an expected signature word. The default four-cell vector gives a maximal-length sequence of 15 states.

Top module: `ca_rule_reg`

## Requirements
- R1: While rst_n is low, the state is RESET_SEED, which is 4'b0001 by default.
- R2: When load_i is high at a clock edge, the next state is seed_i, whatever en_i and mode_i are.
- R3: Cell i is state_o[i], and cell 0 is the left end. In generate mode (mode_i = 0) with en_i high, cell i becomes left ^ right ^ (RULES[i] ? own : 0). RULES[i] = 1 selects rule 150. A missing neighbour reads as 0. The default RULES is 4'b1010, which makes cells 1 and 3 rule 150.
- R4: With the default rule vector and a nonzero seed, generate mode goes through 15 distinct nonzero states and then returns to the seed.
- R5: An all-zero state stays all-zero in generate mode.
- R6: With en_i low and load_i low, the state holds.
- R7: In serial compaction mode (mode_i = 1), ser_left_i is XORed into the next value of cell 0, and ser_right_i into the next value of cell WIDTH-1, on top of the R3 rule.
- R8: In parallel compaction mode (mode_i = 2), par_i[i] is XORed into the next value of cell i, on top of the R3 rule.
- R9: Data inputs not used by the current mode have no effect: par_i in modes 0 and 1, and ser_left_i/ser_right_i in modes 0 and 2.
- R10: Mode 3 holds the state even with en_i high.
- R11: match_o is high exactly when state_o equals golden_i, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load seed_i into the register (highest priority) |
| seed_i | input | WIDTH | Seed word |
| en_i | input | 1 | Step enable |
| mode_i | input | 2 | 0 generate, 1 serial compaction, 2 parallel compaction, 3 hold |
| ser_left_i | input | 1 | Serial input for cell 0 |
| ser_right_i | input | 1 | Serial input for cell WIDTH-1 |
| par_i | input | WIDTH | Parallel response word, bit i goes to cell i |
| golden_i | input | WIDTH | Expected signature word |
| state_o | output | WIDTH | Present register state |
| match_o | output | 1 | state_o equals golden_i |

## Verification
Generate mode is first started from a single set bit, and the first few states are compared against hand-derived values. These values separate rule 90 cells from rule 150 cells and show the zero boundary at each end. A full walk from that seed then confirms the 15-state period, with no repeat and no zero state, and a zero seed confirms the stuck-at-zero state. The compaction modes are tried with one end bit, with both end bits, and with sparse and dense parallel words. Each run also drives the unused inputs with ones, so a wrong input selection shows up in the result. Finally, a multi-word response stream is compressed into a signature and compared against a correct and a corrupted expected word.

// File: rtl/ca_pkg.sv
package ca_pkg;
    typedef enum logic [1:0] {
        MODE_GEN  = 2'd0,
        MODE_SER  = 2'd1,
        MODE_PAR  = 2'd2,
        MODE_HOLD = 2'd3
    } ca_mode_e;
endpackage

// File: rtl/ca_cell.sv
module ca_cell #(
    parameter bit RULE_150 = 1'b0
) (
    input  logic left_i,
    input  logic self_i,
    input  logic right_i,
    input  logic inj_i,
    output logic nxt_o
);
    // rule 90: neighbours only; rule 150 adds the cell's own state
    always_comb begin
        nxt_o = left_i ^ right_i ^ (self_i & RULE_150) ^ inj_i;
    end
endmodule

// File: rtl/ca_inject.sv
module ca_inject
    import ca_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ca_mode_e           mode_i,
    input  logic               ser_left_i,
    input  logic               ser_right_i,
    input  logic [WIDTH-1:0]   par_i,
    output logic [WIDTH-1:0]   inj_o
);
    localparam int LAST = WIDTH - 1;

    always_comb begin
        inj_o = '0;
        unique case (mode_i)
            MODE_SER: begin
                inj_o[0]    = ser_left_i;
                inj_o[LAST] = inj_o[LAST] ^ ser_right_i;
            end
            MODE_PAR: inj_o = par_i;
            default:  inj_o = '0;
        endcase
    end
endmodule

// File: rtl/ca_rule_reg.sv
module ca_rule_reg
    import ca_pkg::*;
#(
    parameter int               WIDTH      = 4,
    parameter logic [WIDTH-1:0] RULES      = 4'b1010,
    parameter logic [WIDTH-1:0] RESET_SEED = 4'b0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             en_i,
    input  logic [1:0]       mode_i,
    input  logic             ser_left_i,
    input  logic             ser_right_i,
    input  logic [WIDTH-1:0] par_i,
    input  logic [WIDTH-1:0] golden_i,
    output logic [WIDTH-1:0] state_o,
    output logic             match_o
);
    localparam int PADW = WIDTH + 2;

    typedef struct packed {
        logic [WIDTH-1:0] cells;
    } ca_state_t;

    ca_state_t        st_d, st_q;
    ca_mode_e         mode;
    logic [PADW-1:0]  padded;
    logic [WIDTH-1:0] inj;
    logic [WIDTH-1:0] step_val;

    assign mode = ca_mode_e'(mode_i);

    // null boundary: a zero sits beyond each end cell
    assign padded = {1'b0, st_q.cells, 1'b0};

    ca_inject #(.WIDTH(WIDTH)) u_inject (
        .mode_i      (mode),
        .ser_left_i  (ser_left_i),
        .ser_right_i (ser_right_i),
        .par_i       (par_i),
        .inj_o       (inj)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        ca_cell #(.RULE_150(RULES[i])) u_cell (
            .left_i  (padded[i]),
            .self_i  (padded[i+1]),
            .right_i (padded[i+2]),
            .inj_i   (inj[i]),
            .nxt_o   (step_val[i])
        );
    end

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.cells = seed_i;
        end else if (en_i && mode != MODE_HOLD) begin
            st_d.cells = step_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cells <= RESET_SEED;
        end else begin
            st_q <= st_d;
        end
    end

    assign state_o = st_q.cells;
    assign match_o = (st_q.cells == golden_i);

    // R2: a load wins over everything
    a_r2_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> state_o == $past(seed_i));

    // R6: idle register holds
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !en_i) |=> $stable(state_o));

    // R10: mode 3 holds even when enabled
    a_r10_mode3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && en_i && mode_i == 2'd3) |=> $stable(state_o));

    // R5: zero is a fixed point of generation
    a_r5_zero_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && en_i && mode_i == 2'd0 && state_o == '0) |=> state_o == '0);

    // R4: a nonzero state never collapses to zero while generating
    a_r4_nonzero_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && en_i && mode_i == 2'd0 && state_o != '0) |=> state_o != '0);

    // R8: a parallel word of zeros steps exactly like generation would
    a_r8_par_zero_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && en_i && mode_i == 2'd2 && par_i == '0 && state_o == '0)
            |=> state_o == '0);
endmodule

// File: tb/tb_ca_rule_reg.sv
module tb_ca_rule_reg;
    localparam int               W     = 4;
    localparam logic [W-1:0]     RULES = 4'b1010;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [W-1:0] seed_i = '0;
    logic         en_i = 1'b0;
    logic [1:0]   mode_i = 2'd0;
    logic         ser_left_i = 1'b0;
    logic         ser_right_i = 1'b0;
    logic [W-1:0] par_i = '0;
    logic [W-1:0] golden_i = '0;
    logic [W-1:0] state_o;
    logic         match_o;

    int n_checks = 0;
    int n_errs = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ca_rule_reg #(.WIDTH(W), .RULES(RULES), .RESET_SEED(4'b0001)) dut (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .seed_i(seed_i),
        .en_i(en_i), .mode_i(mode_i), .ser_left_i(ser_left_i),
        .ser_right_i(ser_right_i), .par_i(par_i), .golden_i(golden_i),
        .state_o(state_o), .match_o(match_o)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 5000)", cycles);
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    // expected next state from the cell rules, null boundary, injections
    function automatic logic [W-1:0] ref_next(input logic [W-1:0] s,
                                              input logic l, input logic r,
                                              input logic [W-1:0] p);
        logic [W-1:0] n;
        for (int i = 0; i < W; i++) begin
            logic lf, rt;
            lf = (i == 0) ? 1'b0 : s[i-1];
            rt = (i == W-1) ? 1'b0 : s[i+1];
            n[i] = lf ^ rt ^ (RULES[i] & s[i]) ^ p[i];
        end
        n[0]   = n[0] ^ l;
        n[W-1] = n[W-1] ^ r;
        return n;
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] s);
        load_i = 1'b1; seed_i = s;
        tick();
        load_i = 1'b0;
    endtask

    task automatic idle_inputs();
        en_i = 1'b0; mode_i = 2'd0; ser_left_i = 1'b0; ser_right_i = 1'b0; par_i = '0;
    endtask

    task automatic t_reset();
        check("R1 reset state", state_o, 4'b0001);
        rst_n = 1'b1;
        tick();
        check("R1 state after release, idle", state_o, 4'b0001);
    endtask

    task automatic t_load_priority();
        en_i = 1'b1; mode_i = 2'd2; par_i = 4'b1111;
        do_load(4'b1001);
        check("R2 load overrides enable and mode", state_o, 4'b1001);
        mode_i = 2'd3;
        do_load(4'b0110);
        check("R2 load in mode 3", state_o, 4'b0110);
        idle_inputs();
    endtask

    task automatic t_gen_steps();
        logic [W-1:0] exp_seq [5] = '{4'b0001, 4'b0010, 4'b0111, 4'b1111, 4'b0011};
        do_load(4'b0001);
        en_i = 1'b1; mode_i = 2'd0;
        for (int k = 1; k < 5; k++) begin
            tick();
            check("R3 generate step", state_o, exp_seq[k]);
        end
        idle_inputs();
    endtask

    task automatic t_period();
        logic [15:0] seen;
        int steps;
        logic [W-1:0] expv;
        seen = '0; steps = 0;
        do_load(4'b0001);
        seen[1] = 1'b1;
        en_i = 1'b1; mode_i = 2'd0;
        expv = 4'b0001;
        for (int k = 0; k < 20; k++) begin
            tick();
            steps++;
            expv = ref_next(expv, 1'b0, 1'b0, '0);
            check("R3 model step", state_o, expv);
            if (state_o == 4'b0001) break;
            if (state_o == '0 || seen[state_o]) begin
                n_checks++; n_errs++;
                $display("FAIL R4 repeat or zero: actual %b expected new nonzero state", state_o);
            end
            seen[state_o] = 1'b1;
        end
        n_checks++;
        if (steps != 15) begin
            n_errs++;
            $display("FAIL R4 period: actual %0d expected 15", steps);
        end
        idle_inputs();
    endtask

    task automatic t_zero();
        do_load(4'b0000);
        en_i = 1'b1; mode_i = 2'd0;
        repeat (3) tick();
        check("R5 zero stays zero", state_o, 4'b0000);
        idle_inputs();
    endtask

    task automatic t_hold();
        do_load(4'b1011);
        en_i = 1'b0; mode_i = 2'd2; par_i = 4'b1111; ser_left_i = 1'b1;
        repeat (2) tick();
        check("R6 hold with enable low", state_o, 4'b1011);
        en_i = 1'b1; mode_i = 2'd3;
        repeat (2) tick();
        check("R10 mode 3 holds", state_o, 4'b1011);
        idle_inputs();
    endtask

    task automatic t_serial();
        do_load(4'b0001);
        en_i = 1'b1; mode_i = 2'd1; ser_left_i = 1'b1; ser_right_i = 1'b1; par_i = 4'b1111;
        tick();
        check("R7 serial both ends (R9 par ignored)", state_o, 4'b1011);
        ser_left_i = 1'b1; ser_right_i = 1'b0; par_i = '0;
        tick();
        check("R7 serial left only", state_o, ref_next(4'b1011, 1'b1, 1'b0, '0));
        idle_inputs();
    endtask

    task automatic t_parallel();
        do_load(4'b0001);
        en_i = 1'b1; mode_i = 2'd2; par_i = 4'b0101; ser_left_i = 1'b1; ser_right_i = 1'b1;
        tick();
        check("R8 parallel word (R9 serial ignored)", state_o, 4'b0111);
        par_i = 4'b1111;
        tick();
        check("R8 parallel dense word", state_o, ref_next(4'b0111, 1'b0, 1'b0, 4'b1111));
        idle_inputs();
    endtask

    task automatic t_gen_ignores();
        do_load(4'b0001);
        en_i = 1'b1; mode_i = 2'd0; par_i = 4'b1111; ser_left_i = 1'b1; ser_right_i = 1'b1;
        tick();
        check("R9 generate ignores data inputs", state_o, 4'b0010);
        idle_inputs();
    endtask

    task automatic t_signature();
        logic [W-1:0] words [6] = '{4'b1100, 4'b0011, 4'b1010, 4'b0000, 4'b0110, 4'b1001};
        logic [W-1:0] sig;
        sig = 4'b0001;
        do_load(4'b0001);
        en_i = 1'b1; mode_i = 2'd2;
        foreach (words[k]) begin
            par_i = words[k];
            sig = ref_next(sig, 1'b0, 1'b0, words[k]);
            tick();
        end
        idle_inputs();
        check("R8 signature after stream", state_o, sig);
        golden_i = sig;
        #1;
        check("R11 match on correct signature", {3'b000, match_o}, 4'b0001);
        golden_i = sig ^ 4'b0100;
        #1;
        check("R11 no match on corrupted signature", {3'b000, match_o}, 4'b0000);
    endtask

    initial begin
        idle_inputs();
        repeat (2) @(negedge clk);
        t_reset();
        t_load_priority();
        t_gen_steps();
        t_period();
        t_zero();
        t_hold();
        t_serial();
        t_parallel();
        t_gen_ignores();
        t_signature();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule